// File: doc/BRIEF.md
# Receive Address Dispatcher with Interrupt Status

This block sits between a bus receive port and a set of receive channels. The port delivers a stream of words. A word flagged as an address selects a target, and the plain data words after it are the payload for that target. The dispatcher compares every address word with the listen address of each started channel. The payload that follows then goes to the lowest-numbered matching channel, until the next address word arrives. Software sets each channel's listen address through a staged register. A write to the init register copies the staged value into the active copy and starts the channel.

When an address word matches no started channel, the dispatcher stops reading the port and leaves that word at the head. It sets the unknown-address flag and so asks for an interrupt. While the port is stalled, software can read the offending address through a snoop register. The stall ends in one of two ways. A status-register read discards the offending address, and its payload is dropped after it. An init write can instead start a channel that now matches, and the held payload then goes to that channel.

The block also holds the interrupt status word. It has a pending bit for each channel, set by that channel's done pulse and cleared by writing 1. It also has two flags, ignored-transmit and unknown-address, that clear when the status word is read. One active-high interrupt line is driven from the status word and an enable bit in the control register.

Top module: `rx_addr_dispatch`

## Requirements
- R1: After reset, no channel is started, the status word and control register read 0, irq is 0, and bus_re is 0 while the port is empty.
- R2: A write to register select 1 (init) starts every channel k whose data bit k is 1 and loads its staged listen address (select 4+k). A channel whose bit is 0 keeps its previous active address.
- R3: A matched address word (bus_av=1) is consumed and not delivered. Each data word consumed after it is presented on ch_data with ch_valid[k] set, one cycle after its read, until the next address word.
- R4: An address word that matches no started channel is not read (bus_re stays 0). Status bit DATA_W-1 (unknown address) is set.
- R5: While stalled, a read of select 3 (snoop) returns the value on bus_data.
- R6: A status read (select 2) during a stall consumes the offending address word. The payload after it is read and dropped, and the read clears bits DATA_W-1 and DATA_W-2.
- R7: An init write that starts a channel matching the stalled address ends the stall, and the held payload goes to that channel.
- R8: A pulse on ch_done_evt[k] sets status bit k. Writing the status select with data bit k = 1 clears it, and a 0 bit leaves it unchanged.
- R9: A pulse on tx_skip_evt sets status bit DATA_W-2, which the next status read clears.
- R10: irq is 1 exactly when control bit 1 (enable) is set and some status bit is set. It follows a change one cycle later.
- R11: When several started channels listen to the same address, the lowest-numbered one receives the payload.
- R12: cfg_rdata carries the selected register one cycle after cfg_rd: select 0 returns the enable in bit 1, and select 4+k returns channel k's staged listen address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_sel | input | SEL_W | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data, registered |
| bus_data | input | DATA_W | Word at head of receive port |
| bus_av | input | 1 | Head word is an address |
| bus_empty | input | 1 | Receive port has no word |
| bus_re | output | 1 | Consume head word this cycle |
| ch_valid | output | N_CH | One-hot payload strobe per channel |
| ch_data | output | DATA_W | Payload word |
| ch_done_evt | input | N_CH | Channel completion pulses |
| tx_skip_evt | input | 1 | Ignored-transmit pulse |
| irq | output | 1 | Interrupt, active high |

## Verification
A payload word read at one edge shows on ch_valid and ch_data after the next edge. The bench logs deliveries at falling edges, so the exact cycle is irrelevant to the routing checks. A register read is issued for one cycle, and cfg_rdata is sampled at the following falling edge, one cycle after the strobe. A status flag sets on the edge of its event, and irq follows one edge later. The bench therefore checks irq and the stall after waiting several cycles past the stimulus, and it checks bus_re at falling edges while the stall holds.

// File: rtl/rx_disp_pkg.sv
package rx_disp_pkg;
  localparam int unsigned SEL_CTRL    = 0;
  localparam int unsigned SEL_INIT    = 1;
  localparam int unsigned SEL_STAT    = 2;
  localparam int unsigned SEL_SNOOP   = 3;
  localparam int unsigned SEL_LISTEN0 = 4;
  localparam int unsigned IE_BIT      = 1;
endpackage

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]        active,
  input  logic [N_CH*DATA_W-1:0] listen_flat,
  input  logic [DATA_W-1:0]      word,
  output logic                   hit,
  output logic [IDX_W-1:0]       hit_idx
);
  logic [N_CH-1:0] eq;

  for (genvar k = 0; k < N_CH; k++) begin : g_cmp
    assign eq[k] = active[k] && (listen_flat[k*DATA_W +: DATA_W] == word);
  end

  // lowest index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      if (eq[k]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/rx_route.sv
module rx_route #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_av,
  input  logic              bus_empty,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic              drop_req,
  input  logic              init_evt,
  output logic              bus_re,
  output logic              unk_set,
  output logic [N_CH-1:0]   ch_valid,
  output logic [DATA_W-1:0] ch_data
);
  logic             hold;
  logic             cur_ok;
  logic [IDX_W-1:0] cur_ch;
  logic             miss;
  logic             drop;

  assign miss    = bus_av && !hit;
  assign drop    = hold && drop_req;
  assign bus_re  = !bus_empty && ((!hold && !miss) || drop);
  // an init cycle defers the verdict until the new table is in place
  assign unk_set = !hold && !bus_empty && miss && !init_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= 1'b0;
      cur_ok   <= 1'b0;
      cur_ch   <= '0;
      ch_valid <= '0;
      ch_data  <= '0;
    end else begin
      ch_valid <= '0;
      if (bus_re) begin
        if (bus_av) begin
          cur_ok <= !drop;
          if (!drop) cur_ch <= hit_idx;
        end else if (cur_ok) begin
          ch_valid <= {{(N_CH-1){1'b0}}, 1'b1} << cur_ch;
          ch_data  <= bus_data;
        end
      end
      if (hold && (drop_req || init_evt)) hold <= 1'b0;
      else if (unk_set)                   hold <= 1'b1;
    end
  end

  assert_stall_blocks_read_R4: assert property (@(posedge clk) disable iff (rst)
    (hold && !drop_req) |-> !bus_re);
  assert_single_target_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_valid));
  assert_read_releases_R6: assert property (@(posedge clk) disable iff (rst)
    (hold && drop_req) |=> !hold);
  assert_unknown_stalls_R4: assert property (@(posedge clk) disable iff (rst)
    unk_set |=> (hold && !bus_re) || drop_req || init_evt);
endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   done_evt,
  input  logic              ign_evt,
  input  logic              unk_evt,
  input  logic              w1c_en,
  input  logic [N_CH-1:0]   w1c_mask,
  input  logic              rd_clr,
  input  logic              ie,
  output logic [DATA_W-1:0] status_word,
  output logic              irq
);
  logic [N_CH-1:0] pend;
  logic            f_ign;
  logic            f_unk;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      f_ign <= 1'b0;
      f_unk <= 1'b0;
      irq   <= 1'b0;
    end else begin
      pend  <= (pend & ~(w1c_en ? w1c_mask : '0)) | done_evt;
      f_ign <= ign_evt | (f_ign & ~rd_clr);
      f_unk <= unk_evt | (f_unk & ~rd_clr);
      irq   <= ie & ((|pend) | f_ign | f_unk);
    end
  end

  always_comb begin
    status_word           = '0;
    status_word[N_CH-1:0] = pend;
    status_word[DATA_W-2] = f_ign;
    status_word[DATA_W-1] = f_unk;
  end

  assert_unknown_flag_R4: assert property (@(posedge clk) disable iff (rst)
    unk_evt |=> f_unk);
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !ign_evt && !unk_evt) |=> (!f_ign && !f_unk));
  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    w1c_en |=> ((pend & $past(w1c_mask & ~done_evt)) == '0));
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
endmodule

// File: rtl/rx_addr_dispatch.sv
module rx_addr_dispatch
  import rx_disp_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(N_CH + 4),
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_av,
  input  logic              bus_empty,
  output logic              bus_re,
  output logic [N_CH-1:0]   ch_valid,
  output logic [DATA_W-1:0] ch_data,
  input  logic [N_CH-1:0]   ch_done_evt,
  input  logic              tx_skip_evt,
  output logic              irq
);
  logic                   ie;
  logic [DATA_W-1:0]      listen_stage [N_CH];
  logic [N_CH*DATA_W-1:0] listen_flat;
  logic [N_CH-1:0]        active;
  logic                   hit;
  logic [IDX_W-1:0]       hit_idx;
  logic                   unk_set;
  logic [DATA_W-1:0]      status_word;
  logic [DATA_W-1:0]      rd_mux;
  logic                   wr_init, wr_stat, wr_ctrl, rd_stat, init_evt;

  assign wr_ctrl  = cfg_wr && (cfg_sel == SEL_W'(SEL_CTRL));
  assign wr_init  = cfg_wr && (cfg_sel == SEL_W'(SEL_INIT));
  assign wr_stat  = cfg_wr && (cfg_sel == SEL_W'(SEL_STAT));
  assign rd_stat  = cfg_rd && (cfg_sel == SEL_W'(SEL_STAT));
  assign init_evt = wr_init && (|cfg_wdata[N_CH-1:0]);

  always_ff @(posedge clk) begin
    if (rst) ie <= 1'b0;
    else if (wr_ctrl) ie <= cfg_wdata[IE_BIT];
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [DATA_W-1:0] listen_act;
    always_ff @(posedge clk) begin
      if (rst) begin
        listen_stage[k] <= '0;
        listen_act      <= '0;
        active[k]       <= 1'b0;
      end else begin
        if (cfg_wr && cfg_sel == SEL_W'(SEL_LISTEN0 + k)) listen_stage[k] <= cfg_wdata;
        if (wr_init && cfg_wdata[k]) begin
          listen_act <= listen_stage[k];
          active[k]  <= 1'b1;
        end
      end
    end
    assign listen_flat[k*DATA_W +: DATA_W] = listen_act;

    assert_init_loads_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_init && cfg_wdata[k]) |=> (active[k] && listen_act == $past(listen_stage[k])));
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_sel)
      SEL_W'(SEL_CTRL):  rd_mux[IE_BIT] = ie;
      SEL_W'(SEL_STAT):  rd_mux = status_word;
      SEL_W'(SEL_SNOOP): rd_mux = bus_data;
      default: begin
        for (int k = 0; k < N_CH; k++)
          if (cfg_sel == SEL_W'(SEL_LISTEN0 + k)) rd_mux = listen_stage[k];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  rx_addr_match #(.N_CH(N_CH), .DATA_W(DATA_W)) u_match (
    .active(active), .listen_flat(listen_flat), .word(bus_data),
    .hit(hit), .hit_idx(hit_idx)
  );

  rx_route #(.N_CH(N_CH), .DATA_W(DATA_W)) u_route (
    .clk(clk), .rst(rst), .bus_data(bus_data), .bus_av(bus_av),
    .bus_empty(bus_empty), .hit(hit), .hit_idx(hit_idx),
    .drop_req(rd_stat), .init_evt(init_evt), .bus_re(bus_re),
    .unk_set(unk_set), .ch_valid(ch_valid), .ch_data(ch_data)
  );

  rx_irq_status #(.N_CH(N_CH), .DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .done_evt(ch_done_evt), .ign_evt(tx_skip_evt),
    .unk_evt(unk_set), .w1c_en(wr_stat), .w1c_mask(cfg_wdata[N_CH-1:0]),
    .rd_clr(rd_stat), .ie(ie), .status_word(status_word), .irq(irq)
  );
endmodule

// File: tb/sim_rx_addr_dispatch.sv
module sim_rx_addr_dispatch;
  localparam int N_CH = 4;
  localparam int DW   = 32;
  localparam int SW   = $clog2(N_CH + 4);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          cfg_wr = 0, cfg_rd = 0;
  logic [SW-1:0] cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic [DW-1:0] bus_data;
  logic          bus_av, bus_empty, bus_re, irq;
  logic [N_CH-1:0] ch_valid, ch_done_evt = '0;
  logic [DW-1:0] ch_data;
  logic          tx_skip_evt = 0;

  logic [DW:0] q [64];
  int qlen = 0;
  int ptr  = 0;
  assign bus_empty = (ptr >= qlen);
  assign bus_data  = bus_empty ? '0 : q[ptr][DW-1:0];
  assign bus_av    = bus_empty ? 1'b0 : q[ptr][DW];
  always @(posedge clk) if (bus_re) ptr <= ptr + 1;

  int log_ch [64];
  logic [DW-1:0] log_d [64];
  int nlog = 0;
  always @(negedge clk)
    if (!rst && |ch_valid)
      for (int k = 0; k < N_CH; k++)
        if (ch_valid[k]) begin log_ch[nlog] = k; log_d[nlog] = ch_data; nlog++; end

  rx_addr_dispatch #(.N_CH(N_CH), .DATA_W(DW)) u0 (.*);

  int ntest = 0, nfail = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [DW-1:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = SW'(sel); cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input int sel, output logic [DW-1:0] d);
    @(negedge clk); cfg_rd = 1; cfg_sel = SW'(sel);
    @(negedge clk); cfg_rd = 0; d = cfg_rdata;
  endtask

  task automatic push(input logic av, input logic [DW-1:0] d);
    q[qlen] = {av, d}; qlen++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {av, expected channel (7 = none), word}
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 3'd7, 32'h0000_00F0},
    {1'b1, 3'd7, 32'h0000_0100},
    {1'b0, 3'd0, 32'h0000_00A1},
    {1'b0, 3'd0, 32'h0000_00A2},
    {1'b1, 3'd7, 32'h0000_0200},
    {1'b0, 3'd1, 32'h0000_00B1},
    {1'b1, 3'd7, 32'h0000_0100},
    {1'b0, 3'd0, 32'h0000_00C1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int exp_ch [16];
    logic [DW-1:0] exp_d [16];
    int nexp = 0;
    int base;

    idle(3); rst = 0; idle(1);
    // R1 reset state
    chk("R1 irq", DW'(irq), 0);
    chk("R1 bus_re", DW'(bus_re), 0);
    rd(2, v); chk("R1 status", v, 0);
    rd(0, v); chk("R1 control", v, 0);

    wr(4, 32'h100); wr(5, 32'h200); wr(6, 32'h100); wr(7, 32'h300);
    rd(5, v); chk("R12 listen readback", v, 32'h200);
    wr(1, 32'h7);           // R2 start ch0..ch2, ch3 stays off
    wr(0, 32'h2);           // R10 enable
    rd(0, v); chk("R12 control readback", v, 32'h2);

    // table walk: R3 routing, R11 ch0 wins over ch2 on 0x100
    base = nlog;
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][35], VEC[i][31:0]);
      if (VEC[i][34:32] != 3'd7) begin
        exp_ch[nexp] = int'(VEC[i][34:32]); exp_d[nexp] = VEC[i][31:0]; nexp++;
      end
    end
    idle(15);
    chk("R3 delivery count", DW'(nlog - base), DW'(nexp));
    for (int i = 0; i < nexp; i++) begin
      chk("R3/R11 channel", DW'(log_ch[base + i]), DW'(exp_ch[i]));
      chk("R3 data", log_d[base + i], exp_d[i]);
    end
    chk("R10 irq quiet", DW'(irq), 0);

    // R4/R5/R6 unknown address, released by status read
    base = nlog;
    push(1'b1, 32'h300); push(1'b0, 32'hD1);
    idle(5);
    chk("R4 bus_re held", DW'(bus_re), 0);
    chk("R4 port frozen", DW'(ptr), DW'(qlen - 2));
    chk("R10 irq raised", DW'(irq), 1);
    rd(3, v); chk("R5 snoop", v, 32'h300);
    rd(2, v); chk("R4 unknown bit", v, 32'h8000_0000);
    idle(4);
    chk("R6 port drained", DW'(ptr), DW'(qlen));
    chk("R6 payload dropped", DW'(nlog - base), 0);
    chk("R6 irq cleared", DW'(irq), 0);
    rd(2, v); chk("R6 flags cleared", v, 0);

    // R7 release by starting a matching channel
    push(1'b1, 32'h300); push(1'b0, 32'hE1);
    idle(5);
    chk("R7 stalled first", DW'(bus_re), 0);
    wr(1, 32'h8);
    idle(4);
    chk("R7 delivered count", DW'(nlog - base), 1);
    chk("R7 channel", DW'(log_ch[base]), 3);
    chk("R7 data", log_d[base], 32'hE1);
    rd(2, v); chk("R7 flag from stall", v, 32'h8000_0000);

    // R8 pending bits and write-one-to-clear
    @(negedge clk); ch_done_evt = 4'b0110;
    @(negedge clk); ch_done_evt = '0;
    rd(2, v); chk("R8 pending set", v, 32'h6);
    idle(1); chk("R10 irq on pending", DW'(irq), 1);
    wr(2, 32'h2);
    rd(2, v); chk("R8 w1c bit1", v, 32'h4);
    wr(2, 32'h0);
    rd(2, v); chk("R8 zero write no effect", v, 32'h4);
    wr(0, 32'h0); idle(2);
    chk("R10 irq masked", DW'(irq), 0);
    wr(0, 32'h2); idle(2);
    chk("R10 irq unmasked", DW'(irq), 1);
    wr(2, 32'h4); idle(2);
    chk("R10 irq after clear", DW'(irq), 0);

    // R9 ignored-transmit flag
    @(negedge clk); tx_skip_evt = 1;
    @(negedge clk); tx_skip_evt = 0;
    rd(2, v); chk("R9 ignored bit", v, 32'h4000_0000);
    rd(2, v); chk("R9 cleared by read", v, 0);

    // R2 staged address takes effect only at init of that channel
    base = nlog;
    wr(5, 32'h500);
    push(1'b1, 32'h200); push(1'b0, 32'hF1);
    idle(6);
    chk("R2 old address kept", DW'(nlog - base), 1);
    chk("R2 old route ch1", DW'(log_ch[base]), 1);
    wr(1, 32'h2);
    push(1'b1, 32'h500); push(1'b0, 32'hF2);
    idle(6);
    chk("R2 new address count", DW'(nlog - base), 2);
    chk("R2 new route ch1", DW'(log_ch[base + 1]), 1);
    chk("R2 new data", log_d[base + 1], 32'hF2);

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule